// File: doc/BRIEF.md
# Mode-Switched Parallel Port Host Datapath

This block is the host side of a byte-wide parallel port. A 3-bit mode field, held in an extended control register, sets how the port behaves. The mode decides whether the byte FIFO is live or held clear. It decides whether the direction bit can release the data lines, and whether a data-register read returns the stored byte or the sampled pins. It selects the drive style of the four control outputs (open-collector or push-pull) and which registers appear at the upper offsets.

The host reaches the block through a simple register bus: address, one-cycle write and read strobes, write data, and combinational read data. In forward FIFO mode the queued bytes go out on their own. Each byte is placed on the data lines, then a strobe pulse is sent, then the block waits for the peripheral's busy line to drop. Test mode lets the host fill and drain the FIFO without anything reaching the port. Configuration mode exposes two configuration bytes. The second of these carries encoded interrupt-line and DMA-channel selections.

Top module: `ppmode_core`

## Requirements
- R1: After reset the mode is 000, the data and control registers are 0, the extended control register reads 0x01, the data lines are driven (pd_oe=1) and ctl_pp=0.
- R2: In mode 000 the FIFO is held clear (empty=1, overflow=0). The data lines stay driven whatever the direction bit (control register bit 5) holds, ctl_pp is 0, and a read at 0x000 returns the stored data register.
- R3: In mode 001, direction=1 releases the data lines (pd_oe=0) and direction=0 drives them. A read at 0x000 returns pd_in. Every mode other than 000 gives ctl_pp=1.
- R4: The extended control register at 0x402 reads {mode[7:5], 2'b00, overflow[2], full[1], empty[0]}. A write sets the mode from wdata[7:5]. empty is 1 exactly when the FIFO holds no byte.
- R5: The FIFO holds 16 bytes. A write to a full FIFO is dropped and sets the sticky overflow bit, which clears only while the FIFO is held clear in mode 000.
- R6: In mode 110, writes to 0x400 push the FIFO and reads at 0x400 return and pop the oldest byte. The strobe output stays low, and the data lines keep showing the data register.
- R7: In mode 010 with direction=0, queued bytes go out in FIFO order. Each byte is on pd_out for 2 clocks with strobe (ctl_out[0], active high) low, then strobe is high for 4 clocks while the byte holds.
- R8: After a strobe pulse in mode 010, the next byte is not popped while busy is high. It is sent once busy goes low.
- R9: In mode 010 with direction=1 nothing is sent, the FIFO keeps its bytes and pd_oe=0.
- R10: In mode 111, 0x400 reads the parameter CFG_A_VALUE (default 0x3C) and writes there do not touch the FIFO. 0x401 reads {2'b00, irq_code[5:3], dma_code[2:0]}. irq_code maps 15→110, 14→101, 11→100, 10→011, 9→010, 7→001, 5→111 and any other value→000. dma_code maps 3→011, 2→010, 1→001 and any other value→000.
- R11: ctl_out[3:0] follows control register bits 3:0 (read back at 0x002). The exception is mode 010, where ctl_out[0] comes from the transmit sequencer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe (pops FIFO at 0x400 in mode 110) |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| pd_in | input | 8 | Sampled data-line pins |
| pd_out | output | 8 | Data-line output value |
| pd_oe | output | 1 | Data-line output enable |
| ctl_out | output | 4 | Control lines: [0] strobe, [1] autofeed, [2] init, [3] select-in |
| ctl_pp | output | 1 | 1 = push-pull control drive, 0 = open-collector |
| busy | input | 1 | Peripheral busy |
| irq_sel | input | 4 | Interrupt line number to encode |
| dma_sel | input | 3 | DMA channel number to encode |

## Verification
Some properties are checked by assertions on every cycle. In mode 000 the FIFO is cleared and the data lines are driven. The FIFO count never exceeds its depth, and a dropped write sets the overflow bit. The data lines hold steady under the strobe, and the strobe never lasts longer than its set length. The sequencer stays parked while busy is high. The direction bit stops transmission and releases the lines in the modes where it should, and test mode never produces a sequencer strobe. Other behaviour only the bench's scenarios can show. This covers FIFO ordering across fill and drain, the exact 2-clock setup before each strobe, the readback source per mode, and the full interrupt and DMA encoding tables.

// File: rtl/pp_pkg.sv
package pp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_FIFO  = 3'b010,
    MODE_X3    = 3'b011,
    MODE_X4    = 3'b100,
    MODE_RSV   = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } pp_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_STRB  = 2'd2,
    SQ_WAIT  = 2'd3
  } sq_state_e;

  // Interrupt line number -> 3-bit field of configuration byte B
  function automatic logic [2:0] irq_field(input logic [3:0] line);
    case (line)
      4'd5:    irq_field = 3'b111;
      4'd7:    irq_field = 3'b001;
      4'd9:    irq_field = 3'b010;
      4'd10:   irq_field = 3'b011;
      4'd11:   irq_field = 3'b100;
      4'd14:   irq_field = 3'b101;
      4'd15:   irq_field = 3'b110;
      default: irq_field = 3'b000;
    endcase
  endfunction

  // DMA channel number -> 3-bit field of configuration byte B
  function automatic logic [2:0] dma_field(input logic [2:0] chan);
    if (chan >= 3'd1 && chan <= 3'd3) dma_field = chan;
    else                              dma_field = 3'b000;
  endfunction

  // Extended control register readback layout
  function automatic logic [7:0] ecr_pack(input pp_mode_e m, input logic ovf,
                                          input logic full, input logic empty);
    ecr_pack = {m, 2'b00, ovf, full, empty};
  endfunction

endpackage

// File: rtl/pp_byte_fifo.sv
module pp_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  wire do_push   = push && !full && !clr;
  wire do_pop    = pop && !empty && !clr;
  wire push_drop = push && full && !clr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    ptr_next = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (push_drop) ovf <= 1'b1;
    end
  end

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf);
  // R5
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop) |=> (count == $past(count)));
  // R2
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !ovf));

endmodule

// File: rtl/pp_tx_seq.sv
module pp_tx_seq
  import pp_pkg::*;
#(
  parameter int W          = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_head,
  input  logic         busy,
  output logic         pop,
  output logic         strobe,
  output logic [W-1:0] dout
);
  localparam int MAXC = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  sq_state_e     state_q;
  logic [TW-1:0] cnt_q;
  logic [W-1:0]  byte_q;

  wire setup_done  = (cnt_q == TW'(SETUP_CYC - 1));
  wire strobe_done = (cnt_q == TW'(STROBE_CYC - 1));

  assign pop    = en && (state_q == SQ_IDLE) && !fifo_empty;
  assign strobe = (state_q == SQ_STRB);
  assign dout   = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
    end else if (!en) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (!fifo_empty) begin
          byte_q  <= fifo_head;
          state_q <= SQ_SETUP;
          cnt_q   <= '0;
        end
        SQ_SETUP: if (setup_done) begin
          state_q <= SQ_STRB;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + TW'(1);
        SQ_STRB: if (strobe_done) begin
          state_q <= SQ_WAIT;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + TW'(1);
        SQ_WAIT: if (!busy) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // Independent run-length counter for the strobe pulse
  logic [TW:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run_q <= '0;
    else if (strobe) hi_run_q <= hi_run_q + (TW+1)'(1);
    else             hi_run_q <= '0;
  end

  // R7
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run_q <= (TW+1)'(STROBE_CYC));
  // R7
  strobe_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (strobe ? $stable(dout) : 1'b1));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT && busy && en) |=> !pop);

endmodule

// File: rtl/pp_cfg_window.sv
module pp_cfg_window
  import pp_pkg::*;
(
  input  logic [3:0] irq_sel,
  input  logic [2:0] dma_sel,
  output logic [7:0] cfg_b
);
  logic [2:0] irq_c, dma_c;

  always_comb begin
    irq_c = irq_field(irq_sel);
    dma_c = dma_field(dma_sel);
    cfg_b = {2'b00, irq_c, dma_c};
  end
endmodule

// File: rtl/ppmode_core.sv
module ppmode_core
  import pp_pkg::*;
#(
  parameter int          ADDR_W      = 11,
  parameter int          FIFO_DEPTH  = 16,
  parameter int          SETUP_CYC   = 2,
  parameter int          STROBE_CYC  = 4,
  parameter logic [7:0]  CFG_A_VALUE = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  input  logic [7:0]        pd_in,
  output logic [7:0]        pd_out,
  output logic              pd_oe,
  output logic [3:0]        ctl_out,
  output logic              ctl_pp,
  input  logic              busy,
  input  logic [3:0]        irq_sel,
  input  logic [2:0]        dma_sel
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h002);
  localparam logic [ADDR_W-1:0] OFS_WIN0 = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OFS_WIN1 = ADDR_W'(12'h401);
  localparam logic [ADDR_W-1:0] OFS_ECR  = ADDR_W'(12'h402);
  localparam int                DIR_BIT  = 5;

  pp_mode_e   mode_q;
  logic [7:0] data_q;
  logic [7:0] ctrl_q;

  // named internal events
  logic       dir;
  logic       hit_data, hit_ctrl, hit_win0, hit_win1, hit_ecr;
  logic       fifo_mode_live;
  logic       fifo_clr, fifo_push, host_pop, seq_pop, fifo_pop;
  logic       fifo_empty, fifo_full, fifo_ovf;
  logic [7:0] fifo_head;
  logic       seq_en, seq_strobe;
  logic [7:0] seq_dout;
  logic [7:0] cfg_b;

  assign dir      = ctrl_q[DIR_BIT];
  assign hit_data = (addr == OFS_DATA);
  assign hit_ctrl = (addr == OFS_CTRL);
  assign hit_win0 = (addr == OFS_WIN0);
  assign hit_win1 = (addr == OFS_WIN1);
  assign hit_ecr  = (addr == OFS_ECR);

  assign fifo_mode_live = (mode_q == MODE_FIFO) || (mode_q == MODE_TEST);
  assign fifo_clr  = (mode_q == MODE_STD);
  assign fifo_push = wr_en && hit_win0 && fifo_mode_live;
  assign host_pop  = rd_en && hit_win0 && (mode_q == MODE_TEST);
  assign seq_en    = (mode_q == MODE_FIFO) && !dir;
  assign fifo_pop  = host_pop || seq_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STD;
      data_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (hit_data) data_q <= wdata;
      if (hit_ctrl) ctrl_q <= wdata;
      if (hit_ecr)  mode_q <= pp_mode_e'(wdata[7:5]);
    end
  end

  pp_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .din   (wdata),
    .head  (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full),
    .ovf   (fifo_ovf)
  );

  pp_tx_seq #(.W(BYTE_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (seq_en),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .busy       (busy),
    .pop        (seq_pop),
    .strobe     (seq_strobe),
    .dout       (seq_dout)
  );

  pp_cfg_window u_cfg (
    .irq_sel (irq_sel),
    .dma_sel (dma_sel),
    .cfg_b   (cfg_b)
  );

  // pin side
  always_comb begin
    pd_oe   = (mode_q == MODE_STD) ? 1'b1 : !dir;
    pd_out  = (mode_q == MODE_FIFO) ? seq_dout : data_q;
    ctl_out = ctrl_q[3:0];
    if (mode_q == MODE_FIFO) ctl_out[0] = seq_strobe;
    ctl_pp  = (mode_q != MODE_STD);
  end

  // host readback
  always_comb begin
    rd_data = '0;
    if (hit_data)
      rd_data = (mode_q == MODE_BIDIR) ? pd_in : data_q;
    else if (hit_ctrl)
      rd_data = ctrl_q;
    else if (hit_ecr)
      rd_data = ecr_pack(mode_q, fifo_ovf, fifo_full, fifo_empty);
    else if (hit_win0) begin
      if (mode_q == MODE_CFG)       rd_data = CFG_A_VALUE;
      else if (mode_q == MODE_TEST) rd_data = fifo_head;
    end else if (hit_win1) begin
      if (mode_q == MODE_CFG)       rd_data = cfg_b;
    end
  end

  // R2
  std_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STD) |-> pd_oe);
  // R2
  std_fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STD) |=> (fifo_empty && !fifo_ovf));
  // R3
  bidir_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BIDIR && dir) |-> !pd_oe);
  // R6
  test_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TEST) |-> !seq_strobe);
  // R9
  dir_blocks_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FIFO && dir) |-> (!seq_pop && !pd_oe));
  // R10
  cfg_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CFG && fifo_empty) |=> fifo_empty);

endmodule

// File: tb/sim_ppmode_core.sv
module sim_ppmode_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic [7:0]  pd_in = 8'h00;
  logic [7:0]  pd_out;
  logic        pd_oe;
  logic [3:0]  ctl_out;
  logic        ctl_pp;
  logic        busy = 1'b0;
  logic [3:0]  irq_sel = '0;
  logic [2:0]  dma_sel = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  ppmode_core u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rd_data(rd_data), .pd_in(pd_in), .pd_out(pd_out),
    .pd_oe(pd_oe), .ctl_out(ctl_out), .ctl_pp(ctl_pp), .busy(busy),
    .irq_sel(irq_sel), .dma_sel(dma_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    bus_wr(11'h402, {m, 5'b0});
  endtask

  function automatic logic [2:0] exp_irq(input int n);
    logic [2:0] r;
    r = 3'b000;
    if (n == 15) r = 3'b110;
    if (n == 14) r = 3'b101;
    if (n == 11) r = 3'b100;
    if (n == 10) r = 3'b011;
    if (n == 9)  r = 3'b010;
    if (n == 7)  r = 3'b001;
    if (n == 5)  r = 3'b111;
    return r;
  endfunction

  function automatic logic [2:0] exp_dma(input int n);
    return (n == 1 || n == 2 || n == 3) ? 3'(n) : 3'b000;
  endfunction

  // Transmit monitor results
  int          p_cnt;
  logic [7:0]  p_byte [4];
  int          p_len  [4];
  int          p_pre  [4];

  task automatic watch_tx(input int cycles);
    logic       prev_s;
    logic [7:0] prev_pd;
    int         same;
    p_cnt = 0;
    prev_s = ctl_out[0];
    prev_pd = pd_out;
    same = 0;
    for (int k = 0; k < 4; k++) begin p_byte[k] = 0; p_len[k] = 0; p_pre[k] = 0; end
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ctl_out[0] && !prev_s) begin
        if (p_cnt < 4) begin p_byte[p_cnt] = pd_out; p_pre[p_cnt] = same; end
        p_cnt++;
      end
      if (ctl_out[0] && p_cnt > 0 && p_cnt <= 4) begin
        p_len[p_cnt-1]++;
        if (pd_out != p_byte[p_cnt-1]) p_len[p_cnt-1] = 99;
      end
      if (pd_out != prev_pd) same = 1;
      else if (!ctl_out[0]) same++;
      prev_pd = pd_out;
      prev_s = ctl_out[0];
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(11'h402, d); chk("R1 ecr", d, 8'h01);
    bus_rd(11'h000, d); chk("R1 data", d, 0);
    bus_rd(11'h002, d); chk("R1 ctrl", d, 0);
    chk("R1 oe", pd_oe, 1);
    chk("R1 pp", ctl_pp, 0);
  endtask

  task automatic t_std;
    logic [7:0] d;
    bus_wr(11'h000, 8'h5A);
    bus_wr(11'h002, 8'h2B);
    pd_in = 8'hC3;
    chk("R2 oe with dir=1", pd_oe, 1);
    chk("R2 pd_out", pd_out, 8'h5A);
    bus_rd(11'h000, d); chk("R2 data readback", d, 8'h5A);
    chk("R2 pp", ctl_pp, 0);
    chk("R11 ctl_out", ctl_out, 4'hB);
    bus_rd(11'h002, d); chk("R11 ctrl readback", d, 8'h2B);
    bus_wr(11'h400, 8'h77);
    bus_rd(11'h402, d); chk("R2 fifo held clear", d, 8'h01);
  endtask

  task automatic t_bidir;
    logic [7:0] d;
    set_mode(3'b001);
    chk("R3 dir=1 released", pd_oe, 0);
    chk("R3 pp", ctl_pp, 1);
    bus_rd(11'h000, d); chk("R3 pin readback", d, 8'hC3);
    bus_wr(11'h002, 8'h00);
    chk("R3 dir=0 driven", pd_oe, 1);
    pd_in = 8'h96;
    bus_rd(11'h000, d); chk("R3 pin readback dir0", d, 8'h96);
    set_mode(3'b000);
  endtask

  task automatic t_test_mode;
    logic [7:0] d;
    set_mode(3'b110);
    for (int i = 0; i < 17; i++) bus_wr(11'h400, 8'(8'h10 + i));
    bus_rd(11'h402, d); chk("R5 full+ovf ecr", d, 8'hC6);
    chk("R6 no strobe", ctl_out[0], 0);
    chk("R6 pd_out is data reg", pd_out, 8'h5A);
    for (int i = 0; i < 16; i++) begin
      bus_rd(11'h400, d); chk($sformatf("R6 pop %0d", i), d, 8'(8'h10 + i));
    end
    bus_rd(11'h402, d); chk("R5 ovf sticky, R4 empty", d, 8'hC5);
    set_mode(3'b000);
    set_mode(3'b110);
    bus_rd(11'h402, d); chk("R5 ovf cleared by mode 000", d, 8'hC1);
  endtask

  task automatic t_tx;
    logic [7:0] d;
    bus_wr(11'h002, 8'h00);
    busy = 1'b0;
    set_mode(3'b110);
    bus_wr(11'h400, 8'hA5);
    bus_wr(11'h400, 8'h3C);
    bus_wr(11'h400, 8'h81);
    set_mode(3'b010);
    watch_tx(40);
    chk("R7 pulse count", p_cnt, 3);
    chk("R7 byte0", p_byte[0], 8'hA5);
    chk("R7 byte1", p_byte[1], 8'h3C);
    chk("R7 byte2", p_byte[2], 8'h81);
    for (int k = 0; k < 3; k++) begin
      chk($sformatf("R7 setup %0d", k), p_pre[k], 2);
      chk($sformatf("R7 strobe len %0d", k), p_len[k], 4);
    end
    chk("R7 oe", pd_oe, 1);
    bus_rd(11'h402, d); chk("R4 ecr after tx", d, 8'h41);
    set_mode(3'b000);
  endtask

  task automatic t_busy;
    logic [7:0] d;
    busy = 1'b1;
    set_mode(3'b110);
    bus_wr(11'h400, 8'h11);
    bus_wr(11'h400, 8'h22);
    set_mode(3'b010);
    watch_tx(30);
    chk("R8 one pulse while busy", p_cnt, 1);
    chk("R8 first byte", p_byte[0], 8'h11);
    bus_rd(11'h402, d); chk("R8 second byte held", d, 8'h40);
    busy = 1'b0;
    watch_tx(30);
    chk("R8 pulse after busy low", p_cnt, 1);
    chk("R8 second byte", p_byte[0], 8'h22);
    bus_rd(11'h402, d); chk("R8 drained", d, 8'h41);
    set_mode(3'b000);
  endtask

  task automatic t_dir_block;
    logic [7:0] d;
    bus_wr(11'h002, 8'h20);
    set_mode(3'b110);
    bus_wr(11'h400, 8'h66);
    set_mode(3'b010);
    watch_tx(20);
    chk("R9 no pulses", p_cnt, 0);
    chk("R9 oe off", pd_oe, 0);
    bus_rd(11'h402, d); chk("R9 byte kept", d, 8'h40);
    set_mode(3'b000);
    bus_wr(11'h002, 8'h00);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    set_mode(3'b111);
    bus_rd(11'h400, d); chk("R10 cfg A", d, 8'h3C);
    bus_wr(11'h400, 8'hEE);
    bus_rd(11'h402, d); chk("R10 write no push", d, 8'hE1);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      irq_sel = 4'(n);
      dma_sel = 3'(n % 8);
      bus_rd(11'h401, d);
      chk($sformatf("R10 cfg B irq %0d dma %0d", n, n % 8), d,
          {2'b00, exp_irq(n), exp_dma(n % 8)});
    end
    set_mode(3'b000);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_std();
    t_bidir();
    t_test_mode();
    t_tx();
    t_busy();
    t_dir_block();
    t_cfg();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule